// File: doc/BRIEF.md
# Shared Flash/SRAM Bus Front End

This block sits between a synchronous host and one external bus that carries both a NOR flash and an asynchronous SRAM. The host makes one request at a time through a valid/ready handshake. Each request names the target device, read or write, byte or word width, a byte address and write data. The block places the address on the shared lines and selects exactly one device. It works out which data pins it drives, and it returns read data, or an acknowledge for a write, as a one-cycle response.

In flash byte mode the top data pin is not a data pin. It carries the lowest address bit, which picks the byte inside the addressed word, and pins 8 to 14 are left undriven. The flash strobe lasts a fixed number of cycles. Strobe timing for an SRAM access comes from a separate SRAM timing controller: the block raises `sram_go` and follows that controller's `sram_strobe` and `sram_done`.

The block also owns the flash hardware reset. After its own reset, or after a host reset request made while idle, it holds the flash reset pin low for a set number of cycles. It then waits a set delay, and then waits until the flash reports ready. It accepts no request until this sequence is complete.

Top module: `membus_front`

## Requirements
- R1: A flash access drives `bus_addr[20:0]` with `req_addr[21:1]`. An SRAM access drives `bus_addr[17:0]` with `req_addr[18:1]` and drives `bus_addr[20:18]` to zero. When idle, `bus_addr` is zero.
- R2: A flash byte access drives `byte_n` low. It drives data pin 15 with `req_addr[0]`, leaves pins 14..8 undriven, and drives pins 7..0 only on a write, with `req_wdata[7:0]`. A byte read returns `dq_in[7:0]` zero-extended to 16 bits.
- R3: A flash word access keeps `byte_n` high. A write drives all 16 pins with `req_wdata`. A read drives no pin and returns `dq_in` unchanged.
- R4: `flash_ce_n` is low only while the SRAM is deselected (`sram_ce1_n` high or `sram_ce2` low). During an SRAM access `flash_ce_n` is high. When idle, both devices are deselected.
- R5: `flash_rst_n` is held low for exactly RST_LOW_CYC cycles after `rst_n` is released, and again after a `rst_req` seen while idle and out of reset.
- R6: After `flash_rst_n` rises, `req_ready` stays low for POST_RST_CYC cycles and then until `flash_ready` is high. No flash select happens in that time.
- R7: `req_ready` is high only when the block is idle, out of its reset sequence and `rst_req` is low. After an accept it is low until the response. `rsp_valid` is a single-cycle pulse.
- R8: A flash access holds `flash_ce_n` low, together with `oe_n` (read) or `we_n` (write), for FLASH_ACC_CYC cycles after the accept. `rsp_valid` follows in the next cycle. Read data is `dq_in` as sampled in the last strobe cycle, and a write responds with data zero.
- R9: During an SRAM access `sram_go` is high, the SRAM is selected, and `oe_n` (read) or `we_n` (write) is low exactly while `sram_strobe` is high. The access ends with `rsp_valid` in the cycle after `sram_done` is seen. A word access drives both `sram_ub_n` and `sram_lb_n` low.
- R10: An SRAM byte access selects the lane by `req_addr[0]`: 0 drives `sram_lb_n` low and uses pins 7..0, 1 drives `sram_ub_n` low and uses pins 15..8. A write drives only that lane, with `req_wdata[7:0]`. A read returns that lane zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_sram | input | 1 | 1 targets the SRAM, 0 the flash |
| req_wr | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7..0) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Read data, zero for writes |
| rst_req | input | 1 | Host request to reset the flash again |
| bus_addr | output | 21 | Shared address lines |
| dq_out | output | 16 | Data pin output values |
| dq_oe | output | 16 | Per-pin output enable |
| dq_in | input | 16 | Data pin input values |
| byte_n | output | 1 | Flash width select, low for byte mode |
| flash_ce_n | output | 1 | Flash chip select, active low |
| flash_rst_n | output | 1 | Flash hardware reset, active low |
| flash_ready | input | 1 | Flash ready/busy line, high when released |
| oe_n | output | 1 | Shared output enable strobe |
| we_n | output | 1 | Shared write enable strobe |
| sram_ce1_n | output | 1 | SRAM select, active low |
| sram_ce2 | output | 1 | SRAM select, active high |
| sram_ub_n | output | 1 | SRAM upper lane enable |
| sram_lb_n | output | 1 | SRAM lower lane enable |
| sram_go | output | 1 | SRAM access in progress, to the timing controller |
| sram_strobe | input | 1 | Strobe request from the SRAM timing controller |
| sram_done | input | 1 | SRAM access complete |

## Verification
A wrong access state shows in the same cycle as a wrong chip select, a wrong strobe or a wrong set of driven pins. The bench compares every pin to its model at each clock, so such a slip is caught at once, and a dual select is caught the moment it appears. A miscounted reset or post-reset delay moves the rising edge of `flash_rst_n` or of `req_ready` by at least one cycle, and that edge is compared directly. A wrong byte lane or a missing zero extension only shows in the one cycle that carries `rsp_valid`, and that is the cycle in which it is checked.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_FLASH = 2'd1,
    ACC_SRAM  = 2'd2
  } acc_state_e;

  typedef enum logic [1:0] {
    RST_LOW  = 2'd0,
    RST_HOLD = 2'd1,
    RST_RDY  = 2'd2,
    RST_DONE = 2'd3
  } rst_phase_e;
endpackage

// File: rtl/membus_rst_seq.sv
module membus_rst_seq
  import membus_pkg::*;
#(
  parameter int RST_LOW_CYC  = 8,
  parameter int POST_RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic flash_ready,
  output logic pin_rst_n,
  output logic busy
);
  localparam int MAXC = (RST_LOW_CYC > POST_RST_CYC) ? RST_LOW_CYC : POST_RST_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  rst_phase_e     phase;
  logic [CW-1:0]  cnt;
  wire            low_last  = (cnt == CW'(RST_LOW_CYC - 1));
  wire            hold_last = (cnt == CW'(POST_RST_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= RST_LOW;
      cnt   <= '0;
    end else begin
      case (phase)
        RST_LOW: begin
          if (low_last) begin phase <= RST_HOLD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        RST_HOLD: begin
          if (hold_last) begin phase <= RST_RDY; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        RST_RDY: if (flash_ready) phase <= RST_DONE;
        default: if (go) begin phase <= RST_LOW; cnt <= '0; end
      endcase
    end
  end

  assign pin_rst_n = (phase != RST_LOW);
  assign busy      = (phase != RST_DONE);

  // R5: the pin is released only after the full low count
  assert_rst_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_rst_n) |-> $past(cnt) == CW'(RST_LOW_CYC - 1));
  // R6: a busy flash keeps the sequence busy
  assert_wait_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == RST_RDY && !flash_ready) |=> busy);
endmodule

// File: rtl/membus_pin_map.sv
module membus_pin_map #(
  parameter int FAW = 21,
  parameter int SAW = 18,
  parameter int DW  = 16
) (
  input  logic           flash_act,
  input  logic           sram_act,
  input  logic           wr,
  input  logic           byte_m,
  input  logic [FAW:0]   addr,
  input  logic [DW-1:0]  wdata,
  output logic [FAW-1:0] bus_addr,
  output logic [DW-1:0]  dq_out,
  output logic [DW-1:0]  dq_oe,
  output logic           ub_n,
  output logic           lb_n,
  output logic           byte_n
);
  localparam int HALF = DW / 2;
  localparam logic [DW-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [DW-1:0] HI_MASK = ~LO_MASK;

  always_comb begin
    bus_addr = '0;
    dq_out   = '0;
    dq_oe    = '0;
    ub_n     = 1'b1;
    lb_n     = 1'b1;
    byte_n   = 1'b1;
    if (flash_act) begin
      bus_addr = addr[FAW:1];
      byte_n   = !byte_m;
      if (byte_m) begin
        dq_oe[DW-1]  = 1'b1;
        dq_out[DW-1] = addr[0];
        if (wr) begin
          dq_oe              = dq_oe | LO_MASK;
          dq_out[HALF-1:0]   = wdata[HALF-1:0];
        end
      end else if (wr) begin
        dq_oe  = '1;
        dq_out = wdata;
      end
    end else if (sram_act) begin
      bus_addr[SAW-1:0] = addr[SAW:1];
      ub_n = byte_m && !addr[0];
      lb_n = byte_m && addr[0];
      if (wr) begin
        if (!byte_m) begin
          dq_oe  = '1;
          dq_out = wdata;
        end else if (addr[0]) begin
          dq_oe             = HI_MASK;
          dq_out[DW-1:HALF] = wdata[HALF-1:0];
        end else begin
          dq_oe             = LO_MASK;
          dq_out[HALF-1:0]  = wdata[HALF-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/membus_front.sv
module membus_front
  import membus_pkg::*;
#(
  parameter int FAW           = 21,
  parameter int SAW           = 18,
  parameter int DW            = 16,
  parameter int RST_LOW_CYC   = 8,
  parameter int POST_RST_CYC  = 4,
  parameter int FLASH_ACC_CYC = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_sram,
  input  logic           req_wr,
  input  logic           req_byte,
  input  logic [FAW:0]   req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data,
  input  logic           rst_req,
  output logic [FAW-1:0] bus_addr,
  output logic [DW-1:0]  dq_out,
  output logic [DW-1:0]  dq_oe,
  input  logic [DW-1:0]  dq_in,
  output logic           byte_n,
  output logic           flash_ce_n,
  output logic           flash_rst_n,
  input  logic           flash_ready,
  output logic           oe_n,
  output logic           we_n,
  output logic           sram_ce1_n,
  output logic           sram_ce2,
  output logic           sram_ub_n,
  output logic           sram_lb_n,
  output logic           sram_go,
  input  logic           sram_strobe,
  input  logic           sram_done
);
  localparam int HALF = DW / 2;
  localparam int FCW  = $clog2(FLASH_ACC_CYC + 1);

  // Read result: word as is, byte picked by lane and zero-extended
  function automatic logic [DW-1:0] pick_read(input logic byte_m, input logic is_sram,
                                              input logic a0, input logic [DW-1:0] dq);
    if (!byte_m)          return dq;
    if (is_sram && a0)    return {{(DW-HALF){1'b0}}, dq[DW-1:HALF]};
    return {{(DW-HALF){1'b0}}, dq[HALF-1:0]};
  endfunction

  acc_state_e     st;
  logic [FCW-1:0] cnt;
  logic           r_sram, r_wr, r_byte;
  logic [FAW:0]   r_addr;
  logic [DW-1:0]  r_wdata;
  logic           seq_busy;

  wire in_idle    = (st == ACC_IDLE);
  wire in_flash   = (st == ACC_FLASH);
  wire in_sram    = (st == ACC_SRAM);
  wire rst_go     = rst_req && in_idle && !seq_busy;
  wire accept     = req_valid && req_ready;
  wire flash_last = in_flash && (cnt == FCW'(FLASH_ACC_CYC - 1));
  wire sram_last  = in_sram && sram_done;
  wire acc_end    = flash_last || sram_last;
  wire strobe_on  = in_flash || (in_sram && sram_strobe);

  assign req_ready = in_idle && !seq_busy && !rst_req;

  membus_rst_seq #(.RST_LOW_CYC(RST_LOW_CYC), .POST_RST_CYC(POST_RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .go(rst_go), .flash_ready(flash_ready),
    .pin_rst_n(flash_rst_n), .busy(seq_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ACC_IDLE;
      cnt       <= '0;
      r_sram    <= 1'b0;
      r_wr      <= 1'b0;
      r_byte    <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        r_sram  <= req_sram;
        r_wr    <= req_wr;
        r_byte  <= req_byte;
        r_addr  <= req_addr;
        r_wdata <= req_wdata;
        cnt     <= '0;
        st      <= req_sram ? ACC_SRAM : ACC_FLASH;
      end else if (acc_end) begin
        st        <= ACC_IDLE;
        rsp_valid <= 1'b1;
        rsp_data  <= r_wr ? '0 : pick_read(r_byte, r_sram, r_addr[0], dq_in);
      end else if (in_flash) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign flash_ce_n = !in_flash;
  assign sram_ce1_n = !in_sram;
  assign sram_ce2   = in_sram;
  assign sram_go    = in_sram;
  assign oe_n       = !(strobe_on && !r_wr);
  assign we_n       = !(strobe_on && r_wr);

  membus_pin_map #(.FAW(FAW), .SAW(SAW), .DW(DW)) u_pins (
    .flash_act(in_flash), .sram_act(in_sram), .wr(r_wr), .byte_m(r_byte),
    .addr(r_addr), .wdata(r_wdata), .bus_addr(bus_addr), .dq_out(dq_out),
    .dq_oe(dq_oe), .ub_n(sram_ub_n), .lb_n(sram_lb_n), .byte_n(byte_n)
  );

  // R4: never both devices selected
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_ce_n && !sram_ce1_n && sram_ce2));
  // R6: no flash select while the reset sequence runs
  assert_noflash_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy || !flash_rst_n) |-> flash_ce_n);
  // R7: single response pulse, one request outstanding
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2: byte mode leaves pins 14..8 free and drives pin 15
  assert_byte_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_ce_n && !byte_n) |-> (dq_oe[DW-2:HALF] == '0 && dq_oe[DW-1]));
endmodule

// File: tb/tb_membus_front.sv
`timescale 1ns/1ps
module tb_membus_front;
  localparam int RL = 8, PD = 4, FC = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_sram = 0, req_wr = 0, req_byte = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0, dq_in = '0;
  logic        rst_req = 0, flash_ready = 0, sram_strobe = 0, sram_done = 0;
  logic        req_ready, rsp_valid, byte_n, flash_ce_n, flash_rst_n, oe_n, we_n;
  logic        sram_ce1_n, sram_ce2, sram_ub_n, sram_lb_n, sram_go;
  logic [15:0] rsp_data, dq_out, dq_oe;
  logic [20:0] bus_addr;

  membus_front dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sram(req_sram), .req_wr(req_wr), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rst_req(rst_req),
    .bus_addr(bus_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .byte_n(byte_n),
    .flash_ce_n(flash_ce_n), .flash_rst_n(flash_rst_n), .flash_ready(flash_ready),
    .oe_n(oe_n), .we_n(we_n), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_go(sram_go),
    .sram_strobe(sram_strobe), .sram_done(sram_done)
  );

  always #2 clk = ~clk;

  int ncmp = 0, nerr = 0, cyc = 0;
  bit started = 0;

  // Reference model: rp 0 low,1 hold,2 wait ready,3 done; ap 0 idle,1 flash,2 sram
  int rp = 0, rc = 0, ap = 0, ac = 0, old_ap;
  int a_sram, a_wr, a_byte, a_addr, a_wdata;
  int e_rv = 0, e_rd = 0;
  bit rdy;

  task automatic chk(string tag, string nm, int got, int exp);
    ncmp++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", tag, nm, got, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
  endtask

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL R7 watchdog: got hang expected completion");
      summary();
      $finish;
    end
    if (!rst_n) begin
      rp = 0; rc = 0; ap = 0; ac = 0; e_rv = 0; e_rd = 0;
    end else begin
      old_ap = ap;
      rdy = (ap == 0 && rp == 3 && !rst_req);
      e_rv = 0;
      if (ap == 1) begin
        if (ac == FC - 1) begin
          ap = 0; e_rv = 1;
          e_rd = a_wr ? 0 : (a_byte ? (int'(dq_in) & 'hFF) : int'(dq_in));
        end else ac++;
      end else if (ap == 2) begin
        if (sram_done) begin
          ap = 0; e_rv = 1;
          if (a_wr) e_rd = 0;
          else if (!a_byte) e_rd = int'(dq_in);
          else if (a_addr % 2 == 1) e_rd = int'(dq_in) / 256;
          else e_rd = int'(dq_in) % 256;
        end
      end else if (req_valid && rdy) begin
        a_sram = req_sram; a_wr = req_wr; a_byte = req_byte;
        a_addr = int'(req_addr); a_wdata = int'(req_wdata);
        ap = req_sram ? 2 : 1; ac = 0;
      end
      case (rp)
        0: if (rc == RL - 1) begin rp = 1; rc = 0; end else rc++;
        1: if (rc == PD - 1) begin rp = 2; rc = 0; end else rc++;
        2: if (flash_ready) rp = 3;
        default: if (rst_req && old_ap == 0) begin rp = 0; rc = 0; end
      endcase
    end
  end

  // Compare every output against the model away from the active edge
  always @(negedge clk) begin
    if (started) begin
      int e_oe, e_out, e_addr, strobe;
      chk("R5", "flash_rst_n", int'(flash_rst_n), (rp != 0) ? 1 : 0);
      chk("R6", "req_ready", int'(req_ready), (ap == 0 && rp == 3 && !rst_req) ? 1 : 0);
      chk("R4", "flash_ce_n", int'(flash_ce_n), (ap != 1) ? 1 : 0);
      chk("R4", "sram_ce1_n", int'(sram_ce1_n), (ap != 2) ? 1 : 0);
      chk("R4", "sram_ce2", int'(sram_ce2), (ap == 2) ? 1 : 0);
      chk("R9", "sram_go", int'(sram_go), (ap == 2) ? 1 : 0);
      strobe = (ap == 1) || (ap == 2 && sram_strobe);
      chk("R8", "oe_n", int'(oe_n), (strobe && !a_wr) ? 0 : 1);
      chk("R8", "we_n", int'(we_n), (strobe && a_wr) ? 0 : 1);
      chk("R7", "rsp_valid", int'(rsp_valid), e_rv);
      if (e_rv) chk(a_sram ? "R10" : "R2", "rsp_data", int'(rsp_data), e_rd);
      chk("R2", "byte_n", int'(byte_n), (ap == 1 && a_byte) ? 0 : 1);
      e_addr = (ap == 1) ? (a_addr / 2) : (ap == 2) ? ((a_addr / 2) % 'h40000) : 0;
      chk("R1", "bus_addr", int'(bus_addr), e_addr);
      e_oe = 0; e_out = 0;
      if (ap == 1) begin
        if (a_byte) begin
          e_oe = 'h8000 | (a_wr ? 'hFF : 0);
          e_out = ((a_addr % 2) * 'h8000) | (a_wr ? (a_wdata % 256) : 0);
        end else if (a_wr) begin e_oe = 'hFFFF; e_out = a_wdata; end
      end else if (ap == 2 && a_wr) begin
        if (!a_byte) begin e_oe = 'hFFFF; e_out = a_wdata; end
        else if (a_addr % 2 == 1) begin e_oe = 'hFF00; e_out = (a_wdata % 256) * 256; end
        else begin e_oe = 'h00FF; e_out = a_wdata % 256; end
      end
      chk(a_sram ? "R10" : "R3", "dq_oe", int'(dq_oe), e_oe);
      chk(a_sram ? "R10" : "R3", "dq_out", int'(dq_out & dq_oe), e_out);
      chk("R9", "sram_lb_n", int'(sram_lb_n), (ap == 2 && !(a_byte && a_addr % 2 == 1)) ? 0 : 1);
      chk("R9", "sram_ub_n", int'(sram_ub_n), (ap == 2 && !(a_byte && a_addr % 2 == 0)) ? 0 : 1);
    end
  end

  task automatic issue(bit s, bit w, bit b, logic [21:0] a, logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_sram = s; req_wr = w; req_byte = b; req_addr = a; req_wdata = d;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (s) begin
      sram_strobe = 1;
      @(negedge clk);
      @(negedge clk);
      sram_done = 1;
      @(negedge clk);
      sram_done = 0; sram_strobe = 0;
    end else begin
      repeat (FC + 1) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;                                   // R5 reset count, R6 ready wait
    repeat (RL + PD + 10) @(negedge clk);
    flash_ready = 1;
    repeat (3) @(negedge clk);
    dq_in = 16'hA55A;
    issue(0, 0, 0, 22'h2ABCDE, 16'h0000);        // R3 R8 flash word read
    issue(0, 1, 0, 22'h3FFFFE, 16'h1234);        // R3 R8 flash word write
    dq_in = 16'hC3E7;
    issue(0, 0, 1, 22'h000001, 16'h0000);        // R2 byte read, pin 15 high
    issue(0, 0, 1, 22'h155554, 16'h0000);        // R2 byte read, pin 15 low
    issue(0, 1, 1, 22'h0ABC03, 16'hFF5A);        // R2 byte write
    dq_in = 16'h9D42;
    issue(1, 0, 0, 22'h3FFFFE, 16'h0000);        // R1 R9 sram word read, high bits zero
    issue(1, 1, 0, 22'h012344, 16'hBEEF);        // R9 sram word write
    issue(1, 0, 1, 22'h000101, 16'h0000);        // R10 upper lane read
    issue(1, 0, 1, 22'h000100, 16'h0000);        // R10 lower lane read
    issue(1, 1, 1, 22'h00F00F, 16'h77C1);        // R10 upper lane write
    issue(1, 1, 1, 22'h00F00E, 16'h77C1);        // R10 lower lane write
    @(negedge clk);
    rst_req = 1; flash_ready = 0;                // R5 R6 host-requested flash reset
    @(negedge clk);
    rst_req = 0;
    repeat (RL + PD + 6) @(negedge clk);
    flash_ready = 1;
    dq_in = 16'h0F1E;
    issue(0, 0, 0, 22'h100000, 16'h0000);        // R6 access resumes after ready
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule